// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block is the transmit engine of a synchronous serial port. Software places one word at a time into a holding register; the engine moves that word into a shift register and drives it, one bit per transmit bit-clock tick, onto a single serial data line. The bit clock arrives as a one-cycle enable pulse (`bit_en`) from a divider outside the block, so all logic runs on the system clock.

A frame begins only when the configured start event occurs at a tick while a word is held. The event is either unconditional (continuous restart) or an edge of the frame-sync input: rising, falling or either. A frame may open with a synchronization field of up to 16 bits before the payload word. The payload is 1 to 32 bits long and can be sent most- or least-significant bit first. Between frames the line rests at a programmable idle level.

Two flags report the holding register. `tx_ready` says the holding register can take another word. `tx_empty` says that neither the holding register nor the shifter has work. When frame sync is produced next to this block, the bit clock may run at up to half the system clock. When frame sync is an input, the limit is one sixth.

Top module: `sst_tx`

## Requirements
- R1: With a word held but no start event at a tick, no bit is sent: `txd` stays at the idle level and `tx_ready` stays 0.
- R2: `cfg_start_mode` selects the start event, judged only at ticks against the frame-sync value seen at the previous tick: 2'b00 always, 2'b01 rising edge, 2'b10 falling edge, 2'b11 either edge. An edge at a tick with no word held, or the wrong edge for the mode, starts nothing.
- R3: `txd` changes only just after a tick. The first bit of a frame appears at the start tick, and each bit then lasts exactly one tick period.
- R4: The sync field sends `cfg_sync_len` bits of `cfg_sync_data`, from bit (len-1) down to bit 0, before the payload. A length of 0 skips the field, and lengths above 16 act as 16.
- R5: The payload is `cfg_len_m1`+1 bits long. With `cfg_msb_first`=1 it is sent from bit (len-1) down to bit 0; with 0 it is sent from bit 0 upward.
- R6: `tx_ready` rises at the tick at which the held word enters the shift register, which is the tick of its first payload bit. It stays 0 through the sync field.
- R7: A write on `wr_en` makes `tx_ready` 0 from the next clock until the word is transferred.
- R8: `tx_empty` is 1 only when no word is held and no frame (sync or payload) is in progress. `tx_empty`=1 implies `tx_ready`=1.
- R9: When the last payload bit ends and no new frame starts at that tick, `txd` returns to `cfg_idle_level` and `tx_empty` rises if no word is held.
- R10: If a word is held and the start event is present at the tick ending a payload, the next frame, including its sync field, starts at that tick with no idle bit between frames.
- R11: After reset `txd` equals `cfg_idle_level`, `tx_ready`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle transmit bit-clock tick |
| fs_in | input | 1 | Frame-sync input, sampled at ticks |
| cfg_start_mode | input | 2 | Start event: 00 always, 01 rise, 10 fall, 11 either edge |
| cfg_len_m1 | input | 5 | Payload length minus one |
| cfg_msb_first | input | 1 | 1 = most-significant bit first |
| cfg_sync_len | input | 5 | Sync field length, 0 to 16 |
| cfg_sync_data | input | 16 | Sync field pattern |
| cfg_idle_level | input | 1 | Line level between frames |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Word written to the holding register |
| txd | output | 1 | Serial data out |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
A wrong phase or bit counter inside the shifter shows on `txd` at the very next tick: a bit is dropped, repeated or sent in the wrong order, or the line falls to idle early. So the bench compares the line on every tick period, not only at frame boundaries. A holding register that loses or keeps its word by mistake shows on `tx_ready` one clock after the write or the transfer tick. It also shows on `tx_empty` at the tick that ends the frame. The flags are therefore checked on those exact cycles. Start-event faults show as a frame that begins a tick early or late, or never begins, and this is caught in the first expected bit.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;

    typedef enum logic [1:0] {
        START_ALWAYS = 2'b00,
        START_RISE   = 2'b01,
        START_FALL   = 2'b10,
        START_ANY    = 2'b11
    } start_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/sst_start_detect.sv
`timescale 1ns/1ps
module sst_start_detect
    import sst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        fs_in,
    input  start_mode_e mode,
    output logic        start_evt
);

    typedef struct packed {
        logic fs_prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            st_d.fs_prev = fs_in;
        end
        case (mode)
            START_ALWAYS: start_evt = 1'b1;
            START_RISE:   start_evt = fs_in & ~st_q.fs_prev;
            START_FALL:   start_evt = ~fs_in & st_q.fs_prev;
            default:      start_evt = fs_in ^ st_q.fs_prev;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an edge-mode event means the sampled sync level toggled at that tick
    assert_edge_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && start_evt && mode != START_ALWAYS) |=> (st_q.fs_prev != $past(st_q.fs_prev)));

endmodule

// File: rtl/sst_holding.sv
`timescale 1ns/1ps
module sst_holding #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid = 1'b0;
        end
        if (wr_en) begin
            st_d.valid = 1'b1;
            st_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_valid = st_q.valid;
    assign hold_data  = st_q.data;

    assert_write_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_valid);

    assert_ready_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.valid) |-> $past(take));

endmodule

// File: rtl/sst_shifter.sv
`timescale 1ns/1ps
module sst_shifter
    import sst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYNC_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_en,
    input  logic                              start_evt,
    input  logic                              hold_valid,
    input  logic [DATA_W-1:0]                 hold_data,
    input  logic [$clog2(DATA_W)-1:0]         cfg_len_m1,
    input  logic                              cfg_msb_first,
    input  logic [$clog2(SYNC_W+1)-1:0]       cfg_sync_len,
    input  logic [SYNC_W-1:0]                 cfg_sync_data,
    input  logic                              cfg_idle_level,
    output logic                              take,
    output logic                              busy,
    output logic                              txd
);

    localparam int LEN_W  = $clog2(DATA_W);
    localparam int SIDX_W = $clog2(SYNC_W);
    localparam int SLEN_W = $clog2(SYNC_W + 1);

    typedef struct packed {
        phase_e              phase;
        logic [LEN_W-1:0]    cnt;
        logic [SIDX_W-1:0]   scnt;
        logic [DATA_W-1:0]   shreg;
    } shf_t;

    shf_t              st_d, st_q;
    shf_t              launch;
    logic              launch_take;
    logic              frame_go;
    logic [SLEN_W-1:0] sync_eff;

    // Next state when a new frame opens at this tick
    always_comb begin
        sync_eff    = (cfg_sync_len > SLEN_W'(SYNC_W)) ? SLEN_W'(SYNC_W) : cfg_sync_len;
        frame_go    = hold_valid && start_evt;
        launch      = st_q;
        launch_take = 1'b0;
        if (sync_eff != '0) begin
            launch.phase = PH_SYNC;
            launch.scnt  = SIDX_W'(sync_eff - SLEN_W'(1));
        end else begin
            launch.phase = PH_DATA;
            launch.cnt   = cfg_len_m1;
            launch.shreg = hold_data;
            launch_take  = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (bit_en) begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (frame_go) begin
                        st_d = launch;
                        take = launch_take;
                    end
                end
                PH_SYNC: begin
                    if (st_q.scnt == '0) begin
                        st_d.phase = PH_DATA;
                        st_d.cnt   = cfg_len_m1;
                        st_d.shreg = hold_data;
                        take       = 1'b1;
                    end else begin
                        st_d.scnt = st_q.scnt - SIDX_W'(1);
                    end
                end
                PH_DATA: begin
                    if (st_q.cnt == '0) begin
                        if (frame_go) begin
                            st_d = launch;
                            take = launch_take;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end else begin
                        st_d.cnt   = st_q.cnt - LEN_W'(1);
                        st_d.shreg = cfg_msb_first ? (st_q.shreg << 1) : (st_q.shreg >> 1);
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st_q.phase)
            PH_SYNC: txd = cfg_sync_data[st_q.scnt];
            PH_DATA: txd = cfg_msb_first ? st_q.shreg[cfg_len_m1] : st_q.shreg[0];
            default: txd = cfg_idle_level;
        endcase
    end

    assign busy = (st_q.phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(st_q.phase) && $stable(st_q.cnt) && $stable(st_q.scnt)));

    assert_start_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && $past(st_q.phase) == PH_IDLE) |-> $past(start_evt && hold_valid && bit_en));

    assert_take_from_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_valid);

endmodule

// File: rtl/sst_tx.sv
`timescale 1ns/1ps
module sst_tx
    import sst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYNC_W = 16,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int SLEN_W = $clog2(SYNC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fs_in,
    input  logic [1:0]        cfg_start_mode,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              cfg_msb_first,
    input  logic [SLEN_W-1:0] cfg_sync_len,
    input  logic [SYNC_W-1:0] cfg_sync_data,
    input  logic              cfg_idle_level,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);

    logic              start_evt;
    logic              take;
    logic              busy;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;

    sst_start_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .fs_in     (fs_in),
        .mode      (start_mode_e'(cfg_start_mode)),
        .start_evt (start_evt)
    );

    sst_holding #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    sst_shifter #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_shift (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .start_evt      (start_evt),
        .hold_valid     (hold_valid),
        .hold_data      (hold_data),
        .cfg_len_m1     (cfg_len_m1),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_sync_len   (cfg_sync_len),
        .cfg_sync_data  (cfg_sync_data),
        .cfg_idle_level (cfg_idle_level),
        .take           (take),
        .busy           (busy),
        .txd            (txd)
    );

    assign tx_ready = ~hold_valid;
    assign tx_empty = ~hold_valid & ~busy;

    assert_empty_means_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

    assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd == cfg_idle_level));

endmodule

// File: tb/sst_tx_test.sv
`timescale 1ns/1ps
module sst_tx_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_en;
    logic        fs_in;
    logic [1:0]  cfg_start_mode;
    logic [4:0]  cfg_len_m1;
    logic        cfg_msb_first;
    logic [4:0]  cfg_sync_len;
    logic [15:0] cfg_sync_data;
    logic        cfg_idle_level;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        txd;
    logic        tx_ready;
    logic        tx_empty;

    logic [1:0]  div;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    int          cur_slen;

    logic        exp_q[$];
    string       req_q[$];
    logic        bits_q[$];

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) div <= 2'd0;
        else        div <= div + 2'd1;
    end
    assign bit_en = (div == 2'd3);

    sst_tx uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .fs_in          (fs_in),
        .cfg_start_mode (cfg_start_mode),
        .cfg_len_m1     (cfg_len_m1),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_sync_len   (cfg_sync_len),
        .cfg_sync_data  (cfg_sync_data),
        .cfg_idle_level (cfg_idle_level),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .txd            (txd),
        .tx_ready       (tx_ready),
        .tx_empty       (tx_empty)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: one line sample per tick period, compared with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (bit_en === 1'b1 && exp_q.size() > 0) begin
                logic  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(txd, e, r, "txd bit");
            end
        end
    end

    task automatic tick();
        do @(negedge clk); while (bit_en !== 1'b1);
        #2;
    endtask

    task automatic edge_then();
        @(posedge clk);
        #1;
    endtask

    // Drive fs for this tick and record the line value expected in the following period
    task automatic per(input logic fs, input logic e, input string req);
        tick();
        fs_in = fs;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(tx_ready, 0, "R7", "ready after write");
        chk(tx_empty, 0, "R8", "empty after write");
    endtask

    task automatic build(input logic [31:0] w, input int len, input bit msb,
                         input int slen, input logic [15:0] sd);
        for (int i = slen - 1; i >= 0; i--) bits_q.push_back(sd[i]);
        for (int i = 0; i < len; i++) bits_q.push_back(msb ? w[len-1-i] : w[i]);
        cur_slen = slen;
    endtask

    task automatic send_frame(input logic fs_go, input string req);
        int n;
        n = bits_q.size();
        for (int i = 0; i < n; i++) begin
            per(fs_go, bits_q[i], req);
            if (i == 0) begin
                edge_then();
                chk(tx_ready, (cur_slen == 0), "R6", "ready after start tick");
                chk(tx_empty, 0, "R8", "empty during frame");
            end else if (cur_slen > 0 && i == cur_slen) begin
                edge_then();
                chk(tx_ready, 1, "R6", "ready at transfer tick");
            end
        end
        bits_q.delete();
    endtask

    initial begin
        rst_n          = 1'b0;
        fs_in          = 1'b0;
        cfg_start_mode = 2'b01;
        cfg_len_m1     = 5'd7;
        cfg_msb_first  = 1'b1;
        cfg_sync_len   = 5'd0;
        cfg_sync_data  = 16'h0;
        cfg_idle_level = 1'b1;
        wr_en          = 1'b0;
        wr_data        = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(txd,      1, "R11", "reset txd");
        chk(tx_ready, 1, "R11", "reset ready");
        chk(tx_empty, 1, "R11", "reset empty");

        // Rising-edge start, 8-bit MSB-first, no sync field
        per(1'b0, 1'b1, "R11");
        wr_word(32'h0000_00A5);
        per(1'b0, 1'b1, "R1");
        per(1'b0, 1'b1, "R1");
        per(1'b0, 1'b1, "R1");
        chk(tx_ready, 0, "R1", "word not taken without event");
        build(32'h0000_00A5, 8, 1'b1, 0, 16'h0);
        send_frame(1'b1, "R5");
        per(1'b1, 1'b1, "R9");
        edge_then();
        chk(tx_empty, 1, "R9", "empty after frame");
        chk(txd,      1, "R9", "idle level after frame");
        per(1'b0, 1'b1, "R2");

        // Edge with nothing held starts nothing
        per(1'b1, 1'b1, "R2");
        edge_then();
        chk(tx_empty, 1, "R2", "edge without word");
        per(1'b0, 1'b1, "R2");

        // Sync field of 3 bits, 4-bit LSB-first payload
        cfg_sync_len  = 5'd3;
        cfg_sync_data = 16'h0005;
        cfg_len_m1    = 5'd3;
        cfg_msb_first = 1'b0;
        wr_word(32'h0000_0006);
        build(32'h0000_0006, 4, 1'b0, 3, 16'h0005);
        send_frame(1'b1, "R4");
        per(1'b1, 1'b1, "R9");
        per(1'b0, 1'b1, "R9");

        // Falling-edge start, 1-bit payload, idle level 0
        per(1'b0, 1'b0, "R9");
        cfg_idle_level = 1'b0;
        cfg_start_mode = 2'b10;
        cfg_len_m1     = 5'd0;
        cfg_sync_len   = 5'd0;
        cfg_msb_first  = 1'b1;
        wr_word(32'h0000_0001);
        per(1'b1, 1'b0, "R2");
        chk(tx_ready, 0, "R2", "rising edge ignored in falling mode");
        build(32'h0000_0001, 1, 1'b1, 0, 16'h0);
        send_frame(1'b0, "R5");
        per(1'b0, 1'b0, "R9");

        // Either-edge mode, 32-bit payload, sync length 20 acts as 16
        cfg_start_mode = 2'b11;
        cfg_len_m1     = 5'd31;
        cfg_sync_len   = 5'd20;
        cfg_sync_data  = 16'hF00F;
        wr_word(32'h8000_0001);
        build(32'h8000_0001, 32, 1'b1, 16, 16'hF00F);
        send_frame(1'b1, "R4");
        per(1'b1, 1'b0, "R9");
        cfg_sync_len  = 5'd0;
        cfg_msb_first = 1'b0;
        wr_word(32'h0000_0003);
        build(32'h0000_0003, 32, 1'b0, 0, 16'h0);
        send_frame(1'b0, "R2");
        per(1'b0, 1'b1, "R9");
        cfg_idle_level = 1'b1;
        cfg_start_mode = 2'b00;
        cfg_len_m1     = 5'd7;
        cfg_sync_len   = 5'd2;
        cfg_sync_data  = 16'h0002;

        // Continuous mode: two frames back to back, second written mid-frame
        wr_word(32'h0000_003C);
        build(32'h0000_003C, 8, 1'b0, 2, 16'h0002);
        build(32'h0000_00C1, 8, 1'b0, 2, 16'h0002);
        begin
            int n;
            n = bits_q.size();
            for (int i = 0; i < n; i++) begin
                per(1'b0, bits_q[i], "R10");
                if (i == 3) begin
                    chk(tx_ready, 1, "R6", "ready after transfer");
                    wr_word(32'h0000_00C1);
                end
            end
            bits_q.delete();
        end
        per(1'b0, 1'b1, "R9");
        edge_then();
        chk(tx_empty, 1, "R9", "empty after back-to-back");
        per(1'b0, 1'b1, "R9");
        tick();
        tick();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule